// File: doc/BRIEF.md
# Pad Interface Initialization Sequencer

This block runs the short synchronization routine that a storage-card pad interface needs before it can be used. The routine must be re-run after the bus clock changes frequency, after the clock is stopped and started again, and after the timing or function setup changes. Software starts it by writing a control word with its start bit set. The block then drives a sync-enable pulse and a sync-reset pulse toward the I/O logic in a fixed order. It waits a settling period and a fixed tail, and clears the start bit by itself when the routine ends.

The control word also holds four 4-bit duration counts, in clock cycles, and two mode flags. The flags pass straight to the pad logic and have nothing to do with the routine. There is no streaming data path, so every pin is a plain control or status signal. The write port has no back-pressure: a write is taken in the cycle in which `wr_en` is high.

Top module: `phy_init_sequencer`

## Requirements
- R1: A write with bit 31 = 1 while the block is idle starts the routine. `busy_o` and read bit 31 go high in the cycle after the write edge. Both stay high until the routine ends and then read 0.
- R2: The duration counts sit in the control word as follows: bits [11:8] sync-enable length, bits [7:4] gap after sync-enable, bits [3:0] sync-reset length, bits [15:12] settling wait. Read bits [15:0] return the last written counts.
- R3: The phases run in this order: sync-enable, gap, sync-reset, settling wait, tail. `sync_en_o` is high for exactly the sync-enable count, starting in the first busy cycle. `sync_rst_o` is high for exactly its count, starting sync-enable + gap cycles after the first busy cycle. Neither is high while idle.
- R4: `busy_o` stays high for exactly the sum of the four counts plus TAIL_CYCLES (default 8) cycles.
- R5: A count of 0 removes its phase. No cycle is spent on it, and the next phase with a nonzero count follows at once.
- R6: A write with bit 31 = 1 while busy has no effect on the running routine and does not start a second one.
- R7: The counts are captured at the start of the routine. Writes during a routine update the read-back value but do not change the routine in progress.
- R8: `done_o` is high for exactly one cycle: the first cycle after `busy_o` falls.
- R9: Bit 29 (slow-bypass flag) and bit 28 (SDIO flag) are stored on every write and drive `slow_mode_o` and `sdio_mode_o` from the next cycle. A write with bit 31 = 0 does not start the routine.
- R10: After reset all outputs are 0 and `rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word read-back, bit 31 = running |
| sync_en_o | output | 1 | Sync-enable pulse to the I/O logic |
| sync_rst_o | output | 1 | Sync-reset pulse to the I/O logic |
| busy_o | output | 1 | Routine in progress |
| done_o | output | 1 | One-cycle completion pulse |
| slow_mode_o | output | 1 | Slow-bypass flag |
| sdio_mode_o | output | 1 | SDIO flag |

## Verification
The assertions assume that `wr_en` and `wr_data` are synchronous to `clk` and stable around the rising edge. They also assume that TAIL_CYCLES is at least 1, so every routine has a nonzero length that a counter can bound. The stimulus changes inputs only on falling edges and writes one control word per strobe. It includes writes that land during a running routine, to exercise R6 and R7 without breaking these assumptions.

// File: rtl/physeq_pkg.sv
package physeq_pkg;
  localparam int NUM_STAGES = 4;
  localparam int SEL_W      = 2;
  localparam int START_BIT  = 31;
  localparam int SLOW_BIT   = 29;
  localparam int SDIO_BIT   = 28;

  // Stage index doubles as phase code for the counted stages.
  typedef enum logic [2:0] {
    PH_ENA  = 3'd0,
    PH_GAP  = 3'd1,
    PH_RST  = 3'd2,
    PH_WAIT = 3'd3,
    PH_TAIL = 3'd4,
    PH_IDLE = 3'd7
  } phase_e;
endpackage

// File: rtl/physeq_ctrl_reg.sv
module physeq_ctrl_reg
  import physeq_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [31:0]                           wr_data,
  input  logic                                  busy,
  output logic [31:0]                           rd_data,
  output logic                                  start_req,
  output logic [NUM_STAGES-1:0][FIELD_W-1:0]    stage_len,
  output logic                                  slow_o,
  output logic                                  sdio_o
);
  localparam int CFG_W = NUM_STAGES * FIELD_W;
  localparam int PAD_W = SDIO_BIT - CFG_W;
  // Register field slot that feeds each stage, in stage order.
  localparam int SLOT_OF_STAGE [NUM_STAGES] = '{2, 1, 0, 3};

  logic [CFG_W-1:0] cfg_q;
  logic             slow_q;
  logic             sdio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      slow_q <= 1'b0;
      sdio_q <= 1'b0;
    end else if (wr_en) begin
      cfg_q  <= wr_data[CFG_W-1:0];
      slow_q <= wr_data[SLOW_BIT];
      sdio_q <= wr_data[SDIO_BIT];
    end
  end

  assign start_req = wr_en && wr_data[START_BIT];

  // Stage lengths come from the write that starts the routine.
  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    assign stage_len[s] = wr_data[SLOT_OF_STAGE[s]*FIELD_W +: FIELD_W];
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data[30], wr_data[SDIO_BIT-1:CFG_W]};

  assign rd_data = {busy, 1'b0, slow_q, sdio_q, {PAD_W{1'b0}}, cfg_q};
  assign slow_o  = slow_q;
  assign sdio_o  = sdio_q;
endmodule

// File: rtl/physeq_sequencer.sv
module physeq_sequencer
  import physeq_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_req,
  input  logic [NUM_STAGES-1:0][FIELD_W-1:0] stage_len,
  output phase_e                             phase_q,
  output logic                               done_o
);
  localparam int TAIL_W = $clog2(TAIL_CYCLES + 1);
  localparam int CNT_W  = (FIELD_W > TAIL_W) ? FIELD_W : TAIL_W;

  logic [NUM_STAGES-1:0][FIELD_W-1:0] held_q;
  logic [CNT_W-1:0]                   cnt_q;
  logic [2:0]                         first_idx;
  logic [2:0]                         next_idx;

  // First stage at or after 'from' with a nonzero length; tail otherwise.
  function automatic logic [2:0] pick(input int from,
                                      input logic [NUM_STAGES-1:0][FIELD_W-1:0] l);
    int r;
    r = NUM_STAGES;
    for (int i = NUM_STAGES - 1; i >= 0; i--) begin
      if (i >= from && l[i] != '0) r = i;
    end
    return 3'(r);
  endfunction

  function automatic logic [CNT_W-1:0] len_of(input logic [2:0] idx,
                                              input logic [NUM_STAGES-1:0][FIELD_W-1:0] l);
    if (idx < 3'(NUM_STAGES)) return CNT_W'(l[idx[SEL_W-1:0]]);
    return CNT_W'(TAIL_CYCLES);
  endfunction

  always_comb begin
    first_idx = pick(0, stage_len);
    next_idx  = pick(int'(phase_q) + 1, held_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      held_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_req) begin
          held_q  <= stage_len;
          phase_q <= phase_e'(first_idx);
          cnt_q   <= len_of(first_idx, stage_len) - 1'b1;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (phase_q == PH_TAIL) begin
        phase_q <= PH_IDLE;
        done_o  <= 1'b1;
      end else begin
        phase_q <= phase_e'(next_idx);
        cnt_q   <= len_of(next_idx, held_q) - 1'b1;
      end
    end
  end
endmodule

// File: rtl/physeq_drive.sv
module physeq_drive
  import physeq_pkg::*;
(
  input  phase_e phase,
  output logic   sync_en,
  output logic   sync_rst,
  output logic   busy
);
  always_comb begin
    sync_en  = (phase == PH_ENA);
    sync_rst = (phase == PH_RST);
    busy     = (phase != PH_IDLE);
  end
endmodule

// File: rtl/phy_init_sequencer.sv
module phy_init_sequencer
  import physeq_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        sync_en_o,
  output logic        sync_rst_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        slow_mode_o,
  output logic        sdio_mode_o
);
  logic                               start_req;
  logic [NUM_STAGES-1:0][FIELD_W-1:0] stage_len;
  phase_e                             phase;

  physeq_ctrl_reg #(.FIELD_W(FIELD_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .busy      (busy_o),
    .rd_data   (rd_data),
    .start_req (start_req),
    .stage_len (stage_len),
    .slow_o    (slow_mode_o),
    .sdio_o    (sdio_mode_o)
  );

  physeq_sequencer #(.FIELD_W(FIELD_W), .TAIL_CYCLES(TAIL_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stage_len (stage_len),
    .phase_q   (phase),
    .done_o    (done_o)
  );

  physeq_drive u_drive (
    .phase    (phase),
    .sync_en  (sync_en_o),
    .sync_rst (sync_rst_o),
    .busy     (busy_o)
  );
endmodule

// File: rtl/phy_init_sequencer_chk.sv
module phy_init_sequencer_chk #(
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        sync_en_o,
  input logic        sync_rst_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        slow_mode_o,
  input logic        sdio_mode_o
);
  localparam int MAX_RUN = 4 * ((1 << FIELD_W) - 1) + TAIL_CYCLES;

  logic [15:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31] && !busy_o) |=> (busy_o && rd_data[31]));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sync_en_o && !sync_rst_o));

  p_min_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_cnt >= 16'(TAIL_CYCLES)));

  p_max_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_cnt < 16'(MAX_RUN)));

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && run_cnt == 16'd0 && wr_en && wr_data[31]) |=> busy_o);

  p_done_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o));

  p_fall_gives_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slow_mode_o == $past(wr_data[29]) && sdio_mode_o == $past(wr_data[28])));

  p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !(wr_en && wr_data[31])) |=> !busy_o);
endmodule

bind phy_init_sequencer phy_init_sequencer_chk #(
  .FIELD_W(FIELD_W), .TAIL_CYCLES(TAIL_CYCLES)) u_chk (.*);

// File: tb/test_phy_init_sequencer.sv
`timescale 1ns/1ps
module test_phy_init_sequencer;
  localparam int TAIL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sync_en_o, sync_rst_o, busy_o, done_o, slow_mode_o, sdio_mode_o;

  phy_init_sequencer i_phy_init_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sync_en_o(sync_en_o), .sync_rst_o(sync_rst_o), .busy_o(busy_o), .done_o(done_o),
    .slow_mode_o(slow_mode_o), .sdio_mode_o(sdio_mode_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  typedef struct { int tot; int ef; int el; int rf; int rl; } exp_t;
  exp_t sbq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] word(input bit st, input int en, input int gap,
                                      input int rs, input int wt);
    return {st, 3'b000, 12'h000, 4'(wt), 4'(en), 4'(gap), 4'(rs)};
  endfunction

  // Driver: push expected timing, then issue the start write.
  task automatic push_and_start(input int en, input int gap, input int rs, input int wt);
    exp_t e;
    e.tot = en + gap + rs + wt + TAIL;
    e.el  = en;  e.ef = (en != 0) ? 0 : -1;
    e.rl  = rs;  e.rf = (rs != 0) ? en + gap : -1;
    sbq.push_back(e);
    write_reg(word(1'b1, en, gap, rs, wt));
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: measure each routine and compare against the queue.
  int  cyc, m_ef, m_el, m_rf, m_rl;
  bit  in_seq = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) begin
        if (!in_seq) begin
          in_seq = 1'b1; cyc = 0; m_ef = -1; m_el = 0; m_rf = -1; m_rl = 0;
        end
        if (sync_en_o)  begin if (m_ef < 0) m_ef = cyc; m_el++; end
        if (sync_rst_o) begin if (m_rf < 0) m_rf = cyc; m_rl++; end
        cyc++;
      end else begin
        if (in_seq) begin
          in_seq = 1'b0;
          chk(done_o, "R8 done at end", int'(done_o), 1);
          if (sbq.size() == 0) begin
            chk(1'b0, "R6 unexpected routine", cyc, 0);
          end else begin
            exp_t e;
            e = sbq.pop_front();
            chk(cyc == e.tot, "R4 busy length", cyc, e.tot);
            chk(m_el == e.el && m_ef == e.ef, "R3 sync-enable start", m_ef, e.ef);
            chk(m_el == e.el, "R3 sync-enable length", m_el, e.el);
            chk(m_rl == e.rl && m_rf == e.rf, "R3 sync-reset start", m_rf, e.rf);
            chk(m_rl == e.rl, "R3 sync-reset length", m_rl, e.rl);
          end
        end else if (done_o) begin
          chk(1'b0, "R8 extra done", 1, 0);
        end
        if (sync_en_o || sync_rst_o) chk(1'b0, "R3 pulse while idle", 1, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rd_data == 32'h0, "R10 rd_data", int'(rd_data), 0);
    chk({sync_en_o, sync_rst_o, busy_o, done_o, slow_mode_o, sdio_mode_o} == 6'b0,
        "R10 outputs", int'({sync_en_o, sync_rst_o, busy_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1, R2: start bit reads 1 while running, fields read back.
    push_and_start(1, 1, 1, 1);
    chk(rd_data[31] == 1'b1, "R1 start bit while running", int'(rd_data[31]), 1);
    chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
    wait_idle();
    chk(rd_data[31] == 1'b0, "R1 start bit after end", int'(rd_data[31]), 0);
    chk(rd_data[15:0] == 16'h1111, "R2 field readback", int'(rd_data[15:0]), 'h1111);

    push_and_start(3, 2, 4, 5);
    wait_idle();
    chk(rd_data[15:0] == 16'h5324, "R2 field positions", int'(rd_data[15:0]), 'h5324);

    // R5: zero-length phases
    push_and_start(0, 0, 0, 0);
    wait_idle();
    push_and_start(0, 5, 0, 0);
    wait_idle();
    push_and_start(2, 0, 3, 0);
    wait_idle();
    push_and_start(15, 15, 15, 15);
    wait_idle();

    // R7: field writes during a routine
    push_and_start(4, 3, 4, 3);
    write_reg(word(1'b0, 1, 1, 1, 1));
    wait_idle();
    chk(rd_data[15:0] == 16'h1111, "R7 readback after mid-run write", int'(rd_data[15:0]), 'h1111);

    // R6: start write while busy
    push_and_start(5, 5, 5, 5);
    repeat (3) @(negedge clk);
    write_reg(word(1'b1, 1, 2, 1, 2));
    wait_idle();
    repeat (5) @(negedge clk);
    chk(busy_o == 1'b0, "R6 no restart", int'(busy_o), 0);

    // R9: flags without start
    write_reg(32'h2000_0000);
    repeat (3) @(negedge clk);
    chk(slow_mode_o == 1'b1 && sdio_mode_o == 1'b0, "R9 slow flag", int'({slow_mode_o, sdio_mode_o}), 2);
    chk(busy_o == 1'b0, "R9 no start", int'(busy_o), 0);
    write_reg(32'h1000_0000);
    chk(slow_mode_o == 1'b0 && sdio_mode_o == 1'b1, "R9 sdio flag", int'({slow_mode_o, sdio_mode_o}), 1);
    chk(rd_data[29:28] == 2'b01, "R9 flag readback", int'(rd_data[29:28]), 1);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R4 all routines seen", sbq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule